// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a small multi-cycle processor built around one 8-bit accumulator and an 8-bit program counter. Each 16-bit instruction carries a 4-bit opcode in its top nibble and an 8-bit operand in its low byte. Depending on the opcode, that operand is either a constant or a memory address. Code and data share one 256-word synchronous memory behind a single port, so a program can overwrite its own instructions.

Every instruction goes through fetch, decode and execute states. Instructions that read a memory operand add a fourth state for the data read. The memory returns read data one cycle after the address is presented. The accumulator, the program counter and a one-cycle flag for undefined opcodes are brought out so they can be observed. The block has no carry flag.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it is released, pc_o and acc_o are 0, mem_we is 0 and mem_addr is 0, so the first fetch is from address 0.
- R2: Only bits 15:12 (opcode) and bits 7:0 (operand) of an instruction word affect execution. Bits 11:8 are ignored.
- R3: The immediate operations set acc as follows, all modulo 256: opcode 0 loads the operand, 1 adds it, 2 subtracts it and 3 ANDs it.
- R4: Opcode 4 loads bits 7:0 of M[operand] into acc. Opcode 6 adds them to acc and opcode 7 subtracts them from acc, modulo 256. Bits 15:8 of the memory word are ignored.
- R5: Opcode 5 writes {8'h00, acc} to M[operand] with mem_we high for exactly one cycle.
- R6: Opcode 8 loads pc with the operand.
- R7: Opcode 9 jumps to the operand only when acc is 0. Opcode 10 jumps only when acc is nonzero. Otherwise pc increments.
- R8: Opcodes 11 to 15 leave acc and memory unchanged, advance pc by one and raise illegal_o for exactly one cycle.
- R9: A sequential pc increment from 255 wraps to 0.
- R10: Opcodes 4, 6 and 7 take 4 cycles. All other opcodes take 3 cycles. acc and pc change only at the last edge of an instruction.
- R11: A word written by opcode 5 is executed as an instruction when the pc later reaches its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for fetch, operand read or store |
| mem_wdata | output | 16 | Store data, the accumulator zero-extended |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| acc_o | output | 8 | Accumulator value |
| pc_o | output | 8 | Program counter value |
| illegal_o | output | 1 | One-cycle pulse after an undefined opcode executes |

## Verification
The assertions assume a memory that returns the addressed word exactly one cycle after the address is presented, and that applies a write at the edge where mem_we is sampled high. They also assume reset is held for at least one edge before the first check. The bench memory model is built to that contract. Its random instruction words draw from all sixteen opcodes with random ignored bits, so stores, jumps and undefined opcodes all occur, and a stray store may overwrite code in a way the reference model reproduces. Reset is always applied while the memory is being loaded.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_MEM    = 2'd3
    } cpu_state_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2,
        ALU_AND  = 2'd3
    } alu_op_e;

    localparam logic [OPC_W-1:0] OP_MOVE  = 4'h0;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'h1;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'h2;
    localparam logic [OPC_W-1:0] OP_AND   = 4'h3;
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'h4;
    localparam logic [OPC_W-1:0] OP_STORE = 4'h5;
    localparam logic [OPC_W-1:0] OP_ADDM  = 4'h6;
    localparam logic [OPC_W-1:0] OP_SUBM  = 4'h7;
    localparam logic [OPC_W-1:0] OP_JMP   = 4'h8;
    localparam logic [OPC_W-1:0] OP_JZ    = 4'h9;
    localparam logic [OPC_W-1:0] OP_JNZ   = 4'hA;

    function automatic alu_op_e alu_sel(input logic [OPC_W-1:0] opc);
        case (opc)
            OP_ADD, OP_ADDM: return ALU_ADD;
            OP_SUB, OP_SUBM: return ALU_SUB;
            OP_AND:          return ALU_AND;
            default:         return ALU_PASS;
        endcase
    endfunction

    function automatic logic is_mem_read(input logic [OPC_W-1:0] opc);
        return (opc == OP_LOAD) || (opc == OP_ADDM) || (opc == OP_SUBM);
    endfunction

    function automatic logic is_imm(input logic [OPC_W-1:0] opc);
        return opc[OPC_W-1:2] == '0;
    endfunction

    function automatic logic is_illegal(input logic [OPC_W-1:0] opc);
        return opc > OP_JNZ;
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_cpu_nextpc.sv
module acc_cpu_nextpc
    import acc_cpu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [OPC_W-1:0] opc,
    input  logic             acc_zero,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    target,
    output logic [AW-1:0]    pc_next
);

    logic [AW-1:0] pc_inc;
    logic          take;

    assign pc_inc = pc + AW'(1);

    always_comb begin
        case (opc)
            OP_JMP:  take = 1'b1;
            OP_JZ:   take = acc_zero;
            OP_JNZ:  take = !acc_zero;
            default: take = 1'b0;
        endcase
        pc_next = take ? target : pc_inc;
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [INSTR_W-1:0] mem_wdata,
    output logic               mem_we,
    input  logic [INSTR_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]  acc_o,
    output logic [DATA_W-1:0]  pc_o,
    output logic               illegal_o
);

    localparam int ADDR_W = DATA_W;
    localparam int PAD_W  = INSTR_W - DATA_W;

    typedef struct packed {
        cpu_state_e        st;
        logic [OPC_W-1:0]  opc;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] acc;
        logic [ADDR_W-1:0] pc;
        logic              ill;
    } cpu_regs_t;

    cpu_regs_t r_d, r_q;

    logic [DATA_W-1:0] alu_b, alu_y;
    logic [ADDR_W-1:0] pc_next;
    logic              unused_ir_bits;

    assign unused_ir_bits = ^mem_rdata[INSTR_W-OPC_W-1:DATA_W];

    assign alu_b = (r_q.st == ST_MEM) ? mem_rdata[DATA_W-1:0] : r_q.opnd;

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .op (alu_sel(r_q.opc)),
        .a  (r_q.acc),
        .b  (alu_b),
        .y  (alu_y)
    );

    acc_cpu_nextpc #(.AW(ADDR_W)) u_nextpc (
        .opc      (r_q.opc),
        .acc_zero (r_q.acc == '0),
        .pc       (r_q.pc),
        .target   (r_q.opnd),
        .pc_next  (pc_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ill   = 1'b0;
        mem_addr  = r_q.pc;
        mem_we    = 1'b0;
        mem_wdata = {{PAD_W{1'b0}}, r_q.acc};
        case (r_q.st)
            ST_FETCH: begin
                r_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.opc  = mem_rdata[INSTR_W-1 -: OPC_W];
                r_d.opnd = mem_rdata[DATA_W-1:0];
                r_d.st   = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = r_q.opnd;
                if (is_mem_read(r_q.opc)) begin
                    r_d.st = ST_MEM;
                end else begin
                    r_d.st = ST_FETCH;
                    r_d.pc = pc_next;
                    if (r_q.opc == OP_STORE) begin
                        mem_we = 1'b1;
                    end else if (is_imm(r_q.opc)) begin
                        r_d.acc = alu_y;
                    end else if (is_illegal(r_q.opc)) begin
                        r_d.ill = 1'b1;
                    end
                end
            end
            default: begin
                mem_addr = r_q.opnd;
                r_d.acc  = alu_y;
                r_d.pc   = pc_next;
                r_d.st   = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_o     = r_q.acc;
    assign pc_o      = r_q.pc;
    assign illegal_o = r_q.ill;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == '0 && acc_o == '0 && !mem_we));

    // R8
    ill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> !illegal_o);

    // R8
    ill_acc_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(acc_o));

    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_o != $past(pc_o)) |-> ($past(r_q.st) == ST_EXEC || $past(r_q.st) == ST_MEM));

    // R10
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_o != $past(acc_o)) |-> ($past(r_q.st) == ST_EXEC || $past(r_q.st) == ST_MEM));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [7:0]  acc_o;
    logic [7:0]  pc_o;
    logic        illegal_o;

    always #10 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .acc_o     (acc_o),
        .pc_o      (pc_o),
        .illegal_o (illegal_o)
    );

    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    logic [15:0] rdata_q;
    logic [7:0]  ref_acc;
    logic [7:0]  ref_pc;
    int          errors = 0;
    int          checks = 0;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        rdata_q <= mem[mem_addr];
    end
    assign mem_rdata = rdata_q;

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2: bits 11:8 get random junk
    task automatic put(input int a, input logic [3:0] opc, input logic [7:0] v);
        logic [15:0] w;
        w = {opc, 4'($urandom), v};
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    task automatic put_word(input int a, input logic [15:0] w);
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_reset();
        rst = 1'b0;
        ref_acc = 8'd0;
        ref_pc = 8'd0;
        // R1 checks in the first cycle after release
        chk_eq("R1 pc after reset", int'(pc_o), 0);
        chk_eq("R1 acc after reset", int'(acc_o), 0);
        chk_eq("R1 we after reset", int'(mem_we), 0);
        chk_eq("R1 fetch address", int'(mem_addr), 0);
    endtask

    task automatic ref_step(output int cyc, output bit ill, output string tag);
        logic [15:0] w;
        logic [3:0]  opc;
        logic [7:0]  v;
        logic [7:0]  nxt;
        w = ref_mem[ref_pc];
        opc = w[15:12];
        v = w[7:0];
        nxt = ref_pc + 8'd1;
        cyc = 3;
        ill = 1'b0;
        case (opc)
            4'h0: begin ref_acc = v;           tag = "R2 R3 move"; end
            4'h1: begin ref_acc = ref_acc + v; tag = "R2 R3 add";  end
            4'h2: begin ref_acc = ref_acc - v; tag = "R2 R3 sub";  end
            4'h3: begin ref_acc = ref_acc & v; tag = "R2 R3 and";  end
            4'h4: begin ref_acc = ref_mem[v][7:0];           cyc = 4; tag = "R4 load"; end
            4'h5: begin ref_mem[v] = {8'h00, ref_acc};                 tag = "R5 store"; end
            4'h6: begin ref_acc = ref_acc + ref_mem[v][7:0]; cyc = 4; tag = "R4 addm"; end
            4'h7: begin ref_acc = ref_acc - ref_mem[v][7:0]; cyc = 4; tag = "R4 subm"; end
            4'h8: begin nxt = v; tag = "R6 jumpu"; end
            4'h9: begin if (ref_acc == 8'd0) nxt = v; tag = "R7 jumpz"; end
            4'hA: begin if (ref_acc != 8'd0) nxt = v; tag = "R7 jumpnz"; end
            default: begin ill = 1'b1; tag = "R8 illegal"; end
        endcase
        ref_pc = nxt;
    endtask

    task automatic step();
        int          cyc;
        bit          ill;
        string       tag;
        logic [7:0]  old_pc;
        logic [7:0]  old_acc;
        logic [15:0] w;
        old_pc = ref_pc;
        old_acc = ref_acc;
        w = ref_mem[ref_pc];
        ref_step(cyc, ill, tag);
        repeat (cyc - 1) @(posedge clk);
        @(negedge clk);
        // R10: nothing visible before the last edge
        chk_eq({"R10 pc held ", tag}, int'(pc_o), int'(old_pc));
        if (w[15:12] == 4'h5) begin
            chk_eq("R5 write enable", int'(mem_we), 1);
            chk_eq("R5 write address", int'(mem_addr), int'(w[7:0]));
            chk_eq("R5 write data", int'(mem_wdata), int'({8'h00, old_acc}));
        end
        @(posedge clk);
        @(negedge clk);
        chk_eq({tag, " acc"}, int'(acc_o), int'(ref_acc));
        chk_eq({tag, " pc"}, int'(pc_o), int'(ref_pc));
        chk_eq({tag, " illegal flag"}, int'(illegal_o), int'(ill));
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) put_word(i, 16'h0000);
    endtask

    task automatic compare_mem(input string tag);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk_eq({tag, " mismatching words"}, bad, 0);
        if (bad != 0) $display("  first mismatch at address %0d", first);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));

        // ---------------- directed program ----------------
        hold_reset();
        clear_mem();
        put(0,  4'h0, 8'd255);
        put(1,  4'h1, 8'd1);      // R3 wrap to 0
        put(2,  4'h2, 8'd1);      // 0 - 1 = 255
        put(3,  4'h1, 8'd255);
        put(4,  4'h3, 8'h0F);
        put(5,  4'h5, 8'h80);     // R5
        put(6,  4'h0, 8'd127);
        put(7,  4'h2, 8'd255);    // 127 - 255 = 128
        put(8,  4'h4, 8'h81);     // R4 high byte ignored
        put(9,  4'h6, 8'h82);
        put(10, 4'h7, 8'h80);
        put(11, 4'h3, 8'h00);
        put(12, 4'h9, 8'd14);     // R7 taken
        put(13, 4'h0, 8'h55);
        put(14, 4'hA, 8'd13);     // not taken
        put(15, 4'h1, 8'd1);
        put(16, 4'h9, 8'd13);     // not taken
        put(17, 4'hA, 8'd19);     // taken
        put(18, 4'h0, 8'h55);
        put(19, 4'hB, 8'h33);     // R8
        put(20, 4'hF, 8'hFF);     // R8
        put(21, 4'h0, 8'h2A);
        put(22, 4'h5, 8'd24);     // R11 overwrite address 24
        put(23, 4'h0, 8'h00);
        put(24, 4'h0, 8'h99);
        put(25, 4'h8, 8'hFE);     // R6
        put(254, 4'h1, 8'd1);
        put(255, 4'h1, 8'd1);
        put_word(8'h81, 16'hAB05);
        put_word(8'h82, 16'hFFFF);
        release_reset();

        for (int k = 0; k < 22; k++) step();
        // pc now 24: the overwritten word runs
        chk_eq("R11 pc at patched word", int'(pc_o), 24);
        step();
        chk_eq("R11 self-modified move", int'(acc_o), 8'h2A);
        step();
        chk_eq("R6 jump target", int'(pc_o), 8'hFE);
        step();
        step();
        chk_eq("R9 pc wrap to zero", int'(pc_o), 0);
        step();
        compare_mem("R5 R11 directed memory image");

        // ---------------- pc wrap with an illegal opcode at 255 ----------------
        hold_reset();
        clear_mem();
        put(0, 4'h8, 8'hFF);
        put(255, 4'hC, 8'h00);
        release_reset();
        step();
        step();
        chk_eq("R9 R8 wrap after illegal", int'(pc_o), 0);
        chk_eq("R8 acc untouched", int'(acc_o), 0);

        // ---------------- constrained random ----------------
        for (int run = 0; run < 3; run++) begin
            hold_reset();
            for (int i = 0; i < 256; i++) put_word(i, 16'($urandom));
            release_reset();
            for (int k = 0; k < 600; k++) step();
            compare_mem("R5 R11 random memory image");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule